// File: doc/BRIEF.md
# Flash Write Qualifier and Page Loader

This block is the write front end of a byte-wide flash array behind an asynchronous parallel bus. A fast system clock samples the chip-enable, output-enable and write-enable pins, the address and the data. A write strobe is counted only if three things hold for the whole pulse: it lasts long enough, the pins are in a write state, and the supply is reported good. The strobe is the overlap of chip enable low and write enable low, with output enable held high. It starts when the later of the two enables falls and ends when the first one rises. So a write can be controlled by either pin. The address is taken at the start of the strobe and the data at its end.

Qualified bytes that share one page (the upper address bits) go into a page buffer. When no further byte has been loaded for a set number of clock cycles, the buffered bytes are committed to the internal array. Bytes of the page that were never loaded keep their old content. While the commit runs, the block holds `busy` high and ignores write attempts. During a commit, a read returns status instead of array data: the top data bit is the complement of that bit of the last loaded byte, and the next bit toggles on every new read cycle.

The controller is a three-state machine:
- ST_IDLE goes to ST_LOAD on the first qualified byte (transition *first-load*).
- ST_LOAD stays in ST_LOAD on each further same-page byte, which restarts the idle timer (*reload*). It goes to ST_PROG when the idle timer expires (*load-timeout*).
- ST_PROG goes back to ST_IDLE after PROG_CYC cycles (*commit-done*). That step writes the buffer into the array.

Top module: `flash_page_loader`

## Requirements
- R1: `bus_dout_en` is 1 only while both `bus_ce_n` and `bus_oe_n` are low, seen two clock edges after the pins change. Otherwise it is 0, and the data bus counts as high impedance.
- R2: A strobe of fewer than MIN_CYC clock samples is discarded, where MIN_CYC = ceil(MIN_PULSE_PS / CLK_PS), which is 3 by default. A strobe of MIN_CYC or more samples loads one byte.
- R3: No byte is loaded when output enable is low during the pulse, when chip enable stays high, or when write enable stays high.
- R4: No byte is loaded while `supply_ok` is 0.
- R5: A strobe framed by chip enable (write enable already low) loads a byte just as a strobe framed by write enable does.
- R6: `busy` rises exactly LOAD_TO+3 clock edges after the edge at which the last accepted strobe's releasing pin was seen high. Each further same-page byte restarts this count.
- R7: `busy` stays high for exactly PROG_CYC cycles. Afterwards every loaded byte is in the array.
- R8: While `busy` is high, bit 6 of the read data is 1 on the first read cycle and inverts on each later read cycle.
- R9: While `busy` is high, bit 7 of the read data is the inverse of bit 7 of the last loaded byte, and bits 5..0 equal that byte's bits 5..0. After the commit, a read returns the stored data.
- R10: A byte for a different page, arriving while a page is loading, is dropped and does not restart the timer. Bytes of the page that were not loaded keep their previous value.
- R11: Write attempts while `busy` is high have no effect on the array or on the page being written.
- R12: After reset, `busy` is 0 and `bus_dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | active-low reset |
| bus_ce_n | input | 1 | chip enable, low active |
| bus_oe_n | input | 1 | output enable, low active |
| bus_we_n | input | 1 | write enable, low active |
| bus_addr | input | AW | byte address |
| bus_din | input | DW | write data from host |
| bus_dout | output | DW | read data or status |
| bus_dout_en | output | 1 | drive enable for the data pins |
| supply_ok | input | 1 | 1 when the supply is high enough to program |
| busy | output | 1 | internal write in progress |

## Verification
The pins pass through two synchroniser flops, so read data and the drive enable are due two edges after a pin change. The bench therefore samples reads four edges after driving them, which is past the edge that advances the status toggle. A strobe's release is seen two edges later, and the load state follows on the third edge. This puts the rise of `busy` LOAD_TO+3 edges after the release and its fall PROG_CYC edges after that. The reference model works out both edges from the release cycle it records and compares `busy` one nanosecond after every rising clock edge.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG
    } fpl_state_e;
endpackage

// File: rtl/fpl_sync.sv
module fpl_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST;
            q    <= RST;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fpl_strobe.sv
module fpl_strobe #(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int MIN_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          oe_s,
    input  logic          we_s,
    input  logic          ok_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          acc,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_data
);
    localparam int CW = $clog2(MIN_CYC + 1) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic          st;
    logic          st_q;
    logic [CW-1:0] width_cnt;

    // strobe: overlap of both enables low, output enable high, supply good
    assign st = !ce_s && !we_s && oe_s && ok_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= 1'b0;
            width_cnt <= '0;
            acc_addr  <= '0;
            acc_data  <= '0;
        end else begin
            st_q <= st;
            if (st && !st_q) acc_addr <= addr_s;
            if (st) acc_data <= data_s;
            if (!st) width_cnt <= '0;
            else if (width_cnt != CMAX) width_cnt <= width_cnt + 1'b1;
        end
    end

    assign acc = st_q && !st && (width_cnt >= CW'(MIN_CYC));

    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !acc); // R2
    AST_ACCEPT_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> $past(ok_s)); // R4
endmodule

// File: rtl/flash_page_loader.sv
module flash_page_loader
    import fpl_pkg::*;
#(
    parameter int AW           = 8,
    parameter int PW           = 4,
    parameter int DW           = 8,
    parameter int CLK_PS       = 5000,
    parameter int MIN_PULSE_PS = 15000,
    parameter int LOAD_TO      = 20,
    parameter int PROG_CYC     = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_ce_n,
    input  logic          bus_oe_n,
    input  logic          bus_we_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    input  logic          supply_ok,
    output logic          busy
);
    localparam int PAGE    = 1 << PW;
    localparam int DEPTH   = 1 << AW;
    localparam int TAG_W   = AW - PW;
    localparam int MIN_CYC = (MIN_PULSE_PS + CLK_PS - 1) / CLK_PS;
    localparam int LW      = $clog2(LOAD_TO + 1);
    localparam int PCW     = $clog2(PROG_CYC + 1);

    logic          ce_s, oe_s, we_s, ok_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    logic          acc;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_data;

    fpl_sync #(.W(4), .RST(4'b0111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({supply_ok, bus_we_n, bus_oe_n, bus_ce_n}),
        .q({ok_s, we_s, oe_s, ce_s})
    );

    fpl_sync #(.W(AW + DW), .RST('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_addr, bus_din}),
        .q({addr_s, data_s})
    );

    fpl_strobe #(.AW(AW), .DW(DW), .MIN_CYC(MIN_CYC)) u_strobe (
        .clk(clk), .rst_n(rst_n),
        .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .ok_s(ok_s),
        .addr_s(addr_s), .data_s(data_s),
        .acc(acc), .acc_addr(acc_addr), .acc_data(acc_data)
    );

    fpl_state_e     state, nstate;
    logic [LW-1:0]  idle_tmr;
    logic [PCW-1:0] prog_tmr;
    logic [TAG_W-1:0] tag;
    logic [PAGE-1:0]  page_valid;
    logic [DW-1:0]    pbuf [PAGE];
    logic [DW-1:0]    mem  [DEPTH];
    logic             poll_hi;
    logic [DW-3:0]    poll_lo;
    logic             tgl;
    logic             rd, rd_q;

    logic same_page, load_done, prog_done, load_we, commit;

    assign same_page = (acc_addr[AW-1:PW] == tag);
    assign load_done = (idle_tmr == LW'(LOAD_TO - 1));
    assign prog_done = (prog_tmr == PCW'(PROG_CYC - 1));
    assign load_we   = acc && ((state == ST_IDLE) || (state == ST_LOAD && same_page));
    assign commit    = (state == ST_PROG) && prog_done;
    assign rd        = !ce_s && !oe_s;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (acc) nstate = ST_LOAD;
            ST_LOAD: if (acc && same_page) nstate = ST_LOAD;
                     else if (load_done) nstate = ST_PROG;
            ST_PROG: if (prog_done) nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            idle_tmr   <= '0;
            prog_tmr   <= '0;
            tag        <= '0;
            page_valid <= '0;
            poll_hi    <= 1'b0;
            poll_lo    <= '0;
            tgl        <= 1'b0;
            rd_q       <= 1'b0;
        end else begin
            state <= nstate;
            rd_q  <= rd;
            if (state != ST_LOAD || load_we) idle_tmr <= '0;
            else idle_tmr <= idle_tmr + 1'b1;
            if (state != ST_PROG) prog_tmr <= '0;
            else prog_tmr <= prog_tmr + 1'b1;
            if (state != ST_PROG) tgl <= 1'b0;
            else if (rd && !rd_q) tgl <= ~tgl;
            if (load_we) begin
                poll_hi <= acc_data[DW-1];
                poll_lo <= acc_data[DW-3:0];
                if (state == ST_IDLE) begin
                    tag        <= acc_addr[AW-1:PW];
                    page_valid <= PAGE'(1) << acc_addr[PW-1:0];
                end else begin
                    page_valid <= page_valid | (PAGE'(1) << acc_addr[PW-1:0]);
                end
            end else if (commit) begin
                page_valid <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (load_we) pbuf[acc_addr[PW-1:0]] <= acc_data;
        if (commit) begin
            for (int i = 0; i < PAGE; i++) begin
                if (page_valid[i]) mem[{tag, PW'(i)}] <= pbuf[i];
            end
        end
    end

    always_comb begin
        busy        = (state == ST_PROG);
        bus_dout_en = rd;
        if (state == ST_PROG) bus_dout = {~poll_hi, tgl, poll_lo};
        else bus_dout = mem[addr_s];
    end

    AST_DOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> ($past(!bus_ce_n, 2) && $past(!bus_oe_n, 2))); // R1
    AST_PROG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(page_valid)); // R11
    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (page_valid == '0)); // R7
endmodule

// File: tb/flash_page_loader_test.sv
`timescale 1ns/1ps
module flash_page_loader_test;
    localparam int TO   = 20;
    localparam int PROG = 40;
    localparam int MINC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [7:0] addr = '0, din = '0;
    logic [7:0] dout;
    logic       dout_en, busy;
    logic       sup = 1'b1;

    flash_page_loader uut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
        .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_dout_en(dout_en),
        .supply_ok(sup), .busy(busy)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nerr = 0;
    bit done = 0;
    int cyc = 0;
    bit m_loading = 0, m_busy = 0;
    int m_last = 0, m_pend = 0, m_rdn = 0;
    logic [3:0] m_tag;
    logic [7:0] m_lastd;
    logic [7:0] mmem [int];
    logic [7:0] pb [int];

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, got, exp, cyc);
        end
    endtask

    // cycle model of busy and of the array contents
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            cyc++;
            if (m_loading && cyc == m_last + 3 + TO) begin
                m_loading = 0; m_busy = 1; m_pend = cyc + PROG; m_rdn = 0;
            end
            if (m_busy && cyc == m_pend) begin
                m_busy = 0;
                foreach (pb[k]) mmem[k] = pb[k];
                pb.delete();
            end
            chk("R6/R7 busy", busy, m_busy);
        end
    end

    // mode 0: write enable framed, 1: chip enable framed, 2: chip enable held high
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input int width,
                      input int mode, input bit oe_low);
        bit ok;
        if (mode == 1) begin
            @(negedge clk) we_n = 1'b0;
        end
        @(negedge clk);
        addr = a; din = d; oe_n = oe_low ? 1'b0 : 1'b1;
        if (mode == 0) begin ce_n = 1'b0; we_n = 1'b0; end
        if (mode == 1) ce_n = 1'b0;
        if (mode == 2) we_n = 1'b0;
        repeat (width) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        ok = (width >= MINC) && sup && (mode != 2) && !oe_low && !m_busy &&
             (!m_loading || a[7:4] == m_tag);
        if (ok) begin
            if (!m_loading) begin m_loading = 1; m_tag = a[7:4]; end
            pb[a] = d; m_last = cyc; m_lastd = d;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        logic [7:0] exp;
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        if (m_busy) begin
            m_rdn++;
            exp = {~m_lastd[7], m_rdn[0], m_lastd[5:0]};
        end else begin
            exp = mmem.exists(a) ? mmem[a] : 8'h00;
        end
        chk(req, dout, exp);
        chk("R1 dout_en on read", dout_en, 1'b1);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic gate(input logic c, input logic o);
        @(negedge clk);
        ce_n = c; oe_n = o;
        repeat (4) @(posedge clk);
        #2;
        chk("R1 dout_en gating", dout_en, !c && !o);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_commit();
        while (!m_busy && m_loading) @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk("R12 busy after reset", busy, 1'b0);
        chk("R12 dout_en after reset", dout_en, 1'b0);

        // page 1 load, status reads and write during commit
        wr(8'h10, 8'h11, 4, 0, 0);
        wr(8'h11, 8'h22, 4, 0, 0);
        wr(8'h13, 8'h83, 4, 0, 0);
        while (!m_busy) @(negedge clk);
        rd(8'h10, "R8/R9 poll first read");
        rd(8'h10, "R8/R9 poll second read");
        wr(8'h11, 8'h99, 4, 0, 0); // R11 ignored while busy
        wait_commit();
        rd(8'h10, "R9 data after commit");
        rd(8'h11, "R11 byte not overwritten");
        rd(8'h13, "R7 byte committed");

        // R2 width threshold
        wr(8'h20, 8'h5A, MINC - 1, 0, 0);
        repeat (40) @(negedge clk);
        wr(8'h20, 8'h5A, MINC, 0, 0);
        wait_commit();
        rd(8'h20, "R2 minimum width accepted");

        // R3 and R4 inhibits
        @(negedge clk) sup = 1'b0;
        repeat (3) @(negedge clk);
        wr(8'h10, 8'hEE, 4, 0, 0);
        @(negedge clk) sup = 1'b1;
        repeat (3) @(negedge clk);
        wr(8'h10, 8'hEE, 4, 0, 1);
        wr(8'h10, 8'hEE, 4, 2, 0);
        repeat (40) @(negedge clk);
        rd(8'h10, "R3/R4 inhibited writes left data");

        // R5 chip-enable framed write, R10 untouched neighbours
        wr(8'h11, 8'h3C, 4, 1, 0);
        wait_commit();
        rd(8'h11, "R5 chip enable framed write");
        rd(8'h10, "R10 unloaded byte kept");

        // R10 different page dropped during load
        wr(8'h20, 8'h77, 4, 0, 0);
        wr(8'h13, 8'h00, 4, 0, 0);
        wait_commit();
        rd(8'h20, "R10 loaded page byte");
        rd(8'h13, "R10 other page byte dropped");

        // R1 gating
        gate(1'b0, 1'b1);
        gate(1'b1, 1'b0);
        gate(1'b1, 1'b1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule